// File: doc/BRIEF.md
# Prioritized Transmit Mailbox Arbiter

This block owns a bank of message mailboxes and decides which one goes to the bus next. Each mailbox has an enable bit, a direction bit (transmit or receive) and a 6-bit transmit priority. A host sets transmit requests with write-one-to-set writes. Among the mailboxes that are enabled, set to transmit and pending, the arbiter picks the one with the largest priority value. When two of them hold the same value, the higher-numbered mailbox wins. The choice is handed to a bus engine, which is stubbed here as an idle/done/abort handshake.

A selection is captured in a register only while the engine reports idle. It then stays fixed until the engine completes the frame or aborts it. A completed frame sets that mailbox's acknowledge flag and clears its request. The host clears acknowledge flags with write-one-to-clear writes. A per-mailbox interrupt mask gates the acknowledge flags into one interrupt output, which comes with the number of the highest-numbered flagged mailbox.

Top module: `txmb_arbiter`

## Requirements
- R1: After reset, all enables, directions, masks, priorities, requests and acknowledge flags are zero, and `sel_valid` and `irq_o` are low.
- R2: A host write with `wr_sel`=2 ORs `wr_data` into the request vector `pend_o`. The change is visible after one clock edge, and zero bits leave requests unchanged.
- R3: When the engine is idle, the arbiter selects the qualifying mailbox with the largest priority. A mailbox qualifies when it is pending, enabled (`wr_sel`=0 register) and its direction bit (`wr_sel`=1 register, 1 = receive) is 0.
- R4: Among qualifying mailboxes with equal priority, the highest mailbox number is selected.
- R5: A mailbox whose direction bit is 1 is never selected, even when it is pending with priority 63.
- R6: Writing an enable vector with a mailbox's bit at 0 drops that mailbox's pending request on the same edge. The mailbox then cannot be selected.
- R7: `sel_valid`/`sel_idx` load only on an edge where `eng_idle` is 1 and `sel_valid` is 0. While `sel_valid` is 1 they hold, without `eng_done` or `eng_abort`, whatever new requests arrive.
- R8: `eng_done` while `sel_valid` is 1 clears `sel_valid` and the selected request, and sets the selected acknowledge bit, all on one edge.
- R9: `eng_abort` while `sel_valid` is 1 clears `sel_valid` and keeps the request pending, so the mailbox can be selected again.
- R10: A host write with `wr_sel`=3 clears each acknowledge bit written as one, and zero bits have no effect. A completion on the same edge keeps its bit set.
- R11: One edge after an acknowledge bit is set with its mask bit (`wr_sel`=4 register) at 1, `irq_o` is 1. `irq_mbx_o` then gives the highest such mailbox number, and it is 0 when there is none.
- R12: With no qualifying mailbox, `sel_valid` stays 0 while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register select: 0 enable, 1 direction, 2 request set, 3 acknowledge clear, 4 interrupt mask |
| wr_data | input | NUM_MBX | Host write data, one bit per mailbox |
| prio_we | input | 1 | Priority field write strobe |
| prio_idx | input | IDX_W | Mailbox whose priority is written |
| prio_val | input | PRIO_W | New priority value |
| eng_idle | input | 1 | Bus engine ready to accept a mailbox |
| eng_done | input | 1 | Bus engine finished the selected frame |
| eng_abort | input | 1 | Bus engine gave up the selected frame |
| sel_valid | output | 1 | A mailbox is selected for the bus |
| sel_idx | output | IDX_W | Selected mailbox number |
| pend_o | output | NUM_MBX | Pending transmit requests |
| ack_o | output | NUM_MBX | Transmit acknowledge flags |
| irq_o | output | 1 | Global mailbox interrupt |
| irq_mbx_o | output | IDX_W | Highest flagged, unmasked mailbox number |

## Verification
Host writes and completion pulses take effect on the next rising edge. A selection appears at the edge where idle is sampled. The interrupt and its mailbox number come one edge after the acknowledge flag, because they are registered from the flag. Every task drives its inputs at a falling edge and lets the exact number of rising edges pass, so register results are read half a cycle after their edge and interrupt results one full cycle later. The hold test keeps idle high for several cycles while a stronger request arrives, to show that a selection only changes through the handshake.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  typedef enum logic [2:0] {
    RS_ENABLE  = 3'd0,
    RS_DIR     = 3'd1,
    RS_REQ_SET = 3'd2,
    RS_ACK_CLR = 3'd3,
    RS_IMASK   = 3'd4
  } regsel_e;
endpackage

// File: rtl/txmb_regs.sv
module txmb_regs
  import txmb_pkg::*;
#(
  parameter int NUM_MBX = 32,
  parameter int PRIO_W  = 6,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [2:0]                      wr_sel,
  input  logic [NUM_MBX-1:0]              wr_data,
  input  logic                            prio_we,
  input  logic [IDX_W-1:0]                prio_idx,
  input  logic [PRIO_W-1:0]               prio_val,
  input  logic                            done_vld,
  input  logic [IDX_W-1:0]                done_idx,
  output logic [NUM_MBX-1:0]              en_q,
  output logic [NUM_MBX-1:0]              dir_q,
  output logic [NUM_MBX-1:0]              imask_q,
  output logic [NUM_MBX-1:0]              req_q,
  output logic [NUM_MBX-1:0]              ack_q,
  output logic [NUM_MBX-1:0][PRIO_W-1:0]  prio_q
);
  regsel_e             sel;
  logic [NUM_MBX-1:0]  set_m;
  logic [NUM_MBX-1:0]  clr_m;
  logic [NUM_MBX-1:0]  done_m;
  logic [NUM_MBX-1:0]  en_n;

  assign sel = regsel_e'(wr_sel);

  always_comb begin
    set_m  = (wr_en && sel == RS_REQ_SET) ? wr_data : '0;
    clr_m  = (wr_en && sel == RS_ACK_CLR) ? wr_data : '0;
    en_n   = (wr_en && sel == RS_ENABLE)  ? wr_data : en_q;
    done_m = '0;
    if (done_vld) done_m[done_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      dir_q   <= '0;
      imask_q <= '0;
      req_q   <= '0;
      ack_q   <= '0;
    end else begin
      en_q <= en_n;
      if (wr_en && sel == RS_DIR)   dir_q   <= wr_data;
      if (wr_en && sel == RS_IMASK) imask_q <= wr_data;
      // requests die with their enable; completion clears the winner
      req_q <= (req_q | set_m) & ~done_m & en_n;
      // completion has precedence over a host clear of the same bit
      ack_q <= (ack_q & ~clr_m) | done_m;
    end
  end

  for (genvar g = 0; g < NUM_MBX; g++) begin : g_prio
    always_ff @(posedge clk) begin
      if (rst)
        prio_q[g] <= '0;
      else if (prio_we && prio_idx == IDX_W'(g))
        prio_q[g] <= prio_val;
    end
  end
endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
  parameter int NUM_MBX = 32,
  parameter int PRIO_W  = 6,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic [NUM_MBX-1:0]              qual,
  input  logic [NUM_MBX-1:0][PRIO_W-1:0]  prio,
  output logic                            any,
  output logic [IDX_W-1:0]                win_idx
);
  logic [PRIO_W-1:0] best;

  // ascending scan with >= lets a later (higher) mailbox take a tie
  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = 0; i < NUM_MBX; i++) begin
      if (qual[i] && (!any || prio[i] >= best)) begin
        any     = 1'b1;
        best    = prio[i];
        win_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/txmb_irq.sv
module txmb_irq #(
  parameter int NUM_MBX = 32,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_MBX-1:0] ack_q,
  input  logic [NUM_MBX-1:0] imask_q,
  output logic               irq_o,
  output logic [IDX_W-1:0]   irq_mbx_o
);
  logic [NUM_MBX-1:0] live;
  logic [IDX_W-1:0]   top_idx;

  assign live = ack_q & imask_q;

  always_comb begin
    top_idx = '0;
    for (int i = 0; i < NUM_MBX; i++)
      if (live[i]) top_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      irq_mbx_o <= '0;
    end else begin
      irq_o     <= |live;
      irq_mbx_o <= top_idx;
    end
  end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter #(
  parameter int NUM_MBX = 32,
  parameter int PRIO_W  = 6,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [NUM_MBX-1:0] wr_data,
  input  logic               prio_we,
  input  logic [IDX_W-1:0]   prio_idx,
  input  logic [PRIO_W-1:0]  prio_val,
  input  logic               eng_idle,
  input  logic               eng_done,
  input  logic               eng_abort,
  output logic               sel_valid,
  output logic [IDX_W-1:0]   sel_idx,
  output logic [NUM_MBX-1:0] pend_o,
  output logic [NUM_MBX-1:0] ack_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   irq_mbx_o
);
  logic [NUM_MBX-1:0]             en_q;
  logic [NUM_MBX-1:0]             dir_q;
  logic [NUM_MBX-1:0]             imask_q;
  logic [NUM_MBX-1:0]             req_q;
  logic [NUM_MBX-1:0]             ack_q;
  logic [NUM_MBX-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_MBX-1:0]             qual;
  logic                           any;
  logic [IDX_W-1:0]               win_idx;
  logic                           done_vld;

  assign done_vld = sel_valid && eng_done;

  txmb_regs #(.NUM_MBX(NUM_MBX), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_val(prio_val),
    .done_vld(done_vld), .done_idx(sel_idx),
    .en_q(en_q), .dir_q(dir_q), .imask_q(imask_q),
    .req_q(req_q), .ack_q(ack_q), .prio_q(prio_q)
  );

  assign qual = req_q & en_q & ~dir_q;

  txmb_pick #(.NUM_MBX(NUM_MBX), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
    .qual(qual), .prio(prio_q), .any(any), .win_idx(win_idx)
  );

  txmb_irq #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W)) u_irq (
    .clk(clk), .rst(rst), .ack_q(ack_q), .imask_q(imask_q),
    .irq_o(irq_o), .irq_mbx_o(irq_mbx_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_idx   <= '0;
    end else if (sel_valid) begin
      if (eng_done || eng_abort) sel_valid <= 1'b0;
    end else if (eng_idle && any) begin
      sel_valid <= 1'b1;
      sel_idx   <= win_idx;
    end
  end

  assign pend_o = req_q;
  assign ack_o  = ack_q;
endmodule

// File: rtl/txmb_arbiter_chk.sv
module txmb_arbiter_chk #(
  parameter int NUM_MBX = 32,
  parameter int IDX_W   = $clog2(NUM_MBX)
) (
  input logic               clk,
  input logic               rst,
  input logic               eng_idle,
  input logic               eng_done,
  input logic               eng_abort,
  input logic               sel_valid,
  input logic [IDX_W-1:0]   sel_idx,
  input logic [NUM_MBX-1:0] pend_o,
  input logic [NUM_MBX-1:0] ack_o,
  input logic               irq_o,
  input logic [IDX_W-1:0]   irq_mbx_o
);
  logic [NUM_MBX-1:0] pend_prev;
  logic [NUM_MBX-1:0] ack_prev;
  logic [IDX_W-1:0]   idx_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_prev <= '0;
      ack_prev  <= '0;
      idx_prev  <= '0;
    end else begin
      pend_prev <= pend_o;
      ack_prev  <= ack_o;
      idx_prev  <= sel_idx;
    end
  end

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    sel_valid && !eng_done && !eng_abort |=> sel_valid && $stable(sel_idx)); // R7
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    !sel_valid && !eng_idle |=> !sel_valid); // R7
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_valid) |-> pend_prev[sel_idx]); // R3
  AST_DONE_ACK: assert property (@(posedge clk) disable iff (rst)
    sel_valid && eng_done |=> !sel_valid && ack_o[idx_prev]); // R8
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    sel_valid && eng_abort |=> !sel_valid); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ack_prev[irq_mbx_o]); // R11
endmodule

bind txmb_arbiter txmb_arbiter_chk #(.NUM_MBX(NUM_MBX), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_txmb_arbiter.sv
module tb_txmb_arbiter;
  localparam int N  = 32;
  localparam int PW = 6;
  localparam int IW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_sel = '0;
  logic [N-1:0]  wr_data = '0;
  logic          prio_we = 1'b0;
  logic [IW-1:0] prio_idx = '0;
  logic [PW-1:0] prio_val = '0;
  logic          eng_idle = 1'b0;
  logic          eng_done = 1'b0;
  logic          eng_abort = 1'b0;
  logic          sel_valid;
  logic [IW-1:0] sel_idx;
  logic [N-1:0]  pend_o;
  logic [N-1:0]  ack_o;
  logic          irq_o;
  logic [IW-1:0] irq_mbx_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [N-1:0] exp_ack = '0;

  always #2.5 clk = ~clk;

  txmb_arbiter #(.NUM_MBX(N), .PRIO_W(PW), .IDX_W(IW)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic hw(input logic [2:0] s, input logic [N-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic setp(input int idx, input int v);
    @(negedge clk); prio_we = 1'b1; prio_idx = IW'(idx); prio_val = PW'(v);
    @(posedge clk); @(negedge clk); prio_we = 1'b0;
  endtask

  task automatic arb();
    @(negedge clk); eng_idle = 1'b1;
    @(posedge clk); @(negedge clk); eng_idle = 1'b0;
  endtask

  task automatic done();
    @(negedge clk); eng_done = 1'b1;
    @(posedge clk); @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic pick_and_send(input string req, input int exp_idx);
    arb();
    chk({req, " valid"}, 32'(sel_valid), 32'd1);
    chk({req, " index"}, 32'(sel_idx), 32'(exp_idx));
    done();
    exp_ack[exp_idx] = 1'b1;
    chk("R8 valid drops", 32'(sel_valid), 32'd0);
    chk("R8 ack set", ack_o, exp_ack);
    chk("R8 request cleared", 32'(pend_o[exp_idx]), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 sel_valid", 32'(sel_valid), 32'd0);
    chk("R1 pend", pend_o, 32'd0);
    chk("R1 ack", ack_o, 32'd0);
    chk("R1 irq", 32'(irq_o), 32'd0);
    arb();
    chk("R1 nothing selectable", 32'(sel_valid), 32'd0);
  endtask

  task automatic t_reqset();
    hw(3'd0, '1);
    hw(3'd2, 32'h5);
    chk("R2 set", pend_o, 32'h5);
    hw(3'd2, 32'h0);
    chk("R2 zeros no effect", pend_o, 32'h5);
    hw(3'd2, 32'h10);
    chk("R2 accumulate", pend_o, 32'h15);
    hw(3'd0, 32'h0);
    chk("R6 disable drops", pend_o, 32'h0);
    hw(3'd0, '1);
    chk("R6 re-enable keeps dropped", pend_o, 32'h0);
  endtask

  task automatic t_priority();
    setp(3, 10); setp(7, 40); setp(20, 25);
    hw(3'd2, (32'd1 << 3) | (32'd1 << 7) | (32'd1 << 20));
    pick_and_send("R3 top", 7);
    pick_and_send("R3 second", 20);
    pick_and_send("R3 last", 3);
    arb();
    chk("R12 none qualifies", 32'(sel_valid), 32'd0);
  endtask

  task automatic t_tie_hold();
    setp(9, 33); setp(30, 33); setp(12, 33);
    hw(3'd2, (32'd1 << 9) | (32'd1 << 30) | (32'd1 << 12));
    arb();
    chk("R4 tie valid", 32'(sel_valid), 32'd1);
    chk("R4 tie highest number", 32'(sel_idx), 32'd30);
    setp(31, 63);
    hw(3'd2, 32'd1 << 31);
    @(negedge clk); eng_idle = 1'b1;
    repeat (4) tick();
    eng_idle = 1'b0;
    chk("R7 hold valid", 32'(sel_valid), 32'd1);
    chk("R7 hold index", 32'(sel_idx), 32'd30);
    done();
    exp_ack[30] = 1'b1;
    chk("R8 ack 30", ack_o, exp_ack);
    pick_and_send("R3 new top", 31);
    pick_and_send("R4 tie next", 12);
    pick_and_send("R4 tie low", 9);
  endtask

  task automatic t_dir();
    hw(3'd1, 32'd1 << 5);
    setp(5, 63);
    hw(3'd2, (32'd1 << 5) | (32'd1 << 2));
    pick_and_send("R5 receive skipped", 2);
    arb();
    chk("R5 receive never selected", 32'(sel_valid), 32'd0);
    chk("R5 receive still pending", 32'(pend_o[5]), 32'd1);
  endtask

  task automatic t_enable_drop();
    setp(14, 50);
    hw(3'd2, (32'd1 << 14) | (32'd1 << 1));
    hw(3'd0, ~(32'd1 << 14));
    chk("R6 pending dropped", 32'(pend_o[14]), 32'd0);
    pick_and_send("R6 disabled loses", 1);
    hw(3'd0, '1);
    arb();
    chk("R6 dropped stays out", 32'(sel_valid), 32'd0);
  endtask

  task automatic t_abort();
    hw(3'd2, 32'd1 << 16);
    arb();
    chk("R9 selected", 32'(sel_idx), 32'd16);
    @(negedge clk); eng_abort = 1'b1;
    @(posedge clk); @(negedge clk); eng_abort = 1'b0;
    chk("R9 valid drops", 32'(sel_valid), 32'd0);
    chk("R9 still pending", 32'(pend_o[16]), 32'd1);
    chk("R9 no ack", ack_o, exp_ack);
    pick_and_send("R9 retried", 16);
  endtask

  task automatic t_ack_irq();
    chk("R11 masked no irq", 32'(irq_o), 32'd0);
    hw(3'd4, (32'd1 << 20) | (32'd1 << 3));
    chk("R11 irq not yet", 32'(irq_o), 32'd0);
    tick();
    chk("R11 irq up", 32'(irq_o), 32'd1);
    chk("R11 irq mailbox", 32'(irq_mbx_o), 32'd20);
    hw(3'd3, 32'd1 << 20);
    exp_ack[20] = 1'b0;
    chk("R10 clear", ack_o, exp_ack);
    tick();
    chk("R11 next mailbox", 32'(irq_mbx_o), 32'd3);
    hw(3'd3, 32'd0);
    chk("R10 zeros no effect", ack_o, exp_ack);
    hw(3'd3, 32'd1 << 3);
    exp_ack[3] = 1'b0;
    tick();
    chk("R11 irq down", 32'(irq_o), 32'd0);
    chk("R11 mailbox zero", 32'(irq_mbx_o), 32'd0);
  endtask

  task automatic t_done_vs_clr();
    hw(3'd2, 32'd1 << 25);
    arb();
    chk("R3 single", 32'(sel_idx), 32'd25);
    @(negedge clk);
    eng_done = 1'b1; wr_en = 1'b1; wr_sel = 3'd3; wr_data = 32'd1 << 25;
    @(posedge clk); @(negedge clk);
    eng_done = 1'b0; wr_en = 1'b0; wr_data = '0;
    exp_ack[25] = 1'b1;
    chk("R10 done beats clear", ack_o, exp_ack);
  endtask

  initial begin
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_reqset();
    t_priority();
    t_tie_hold();
    t_dir();
    t_enable_drop();
    t_abort();
    t_ack_irq();
    t_done_vs_clr();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule